// File: doc/BRIEF.md
# Row-Chunked Staging Copy Sequencer

This block turns one rectangular copy between a linear buffer and an image into an ordered stream of command descriptors that go through a small staging area of fixed size. The copy is measured in format blocks: the pixel width and height are converted to block columns and block rows. The staging area holds some number of whole block rows, padded to a pitch of four blocks. The copy is cut into chunks of block rows whose count is a power of two. Slices are walked one at a time, and the chunks of each slice are walked from top to bottom.

For every chunk the block emits a sub-window descriptor that moves the chunk between the image and the staging area. It emits one linear row descriptor per block row that moves that row between the buffer and the staging area. It also emits fence descriptors. The copy direction decides where the fences go. A downstream command writer takes the descriptors over a valid/ready handshake. All copy parameters are captured when the request starts, and a single-cycle done pulse marks the end of the job.

Top module: `row_chunk_seq`

## Requirements
- R1: After reset, `descValid` and `done` are both low and stay low until a start request is accepted.
- R2: Every row descriptor (kind code 2) carries a byte count of ceil(width / block width) × bytes per element.
- R3: Each slice is covered by ceil(height / block height) block rows in total. A row descriptor's `descRow` is the absolute block row index, and its `descRows` is 1.
- R4: The staging pitch is the horizontal block count rounded up to a multiple of 4. The staging address of the k-th row in a chunk (k counting from 0) is staging base + k × staging pitch × bytes per element.
- R5: Let M be the smaller of (STAGE_BYTES / (staging pitch × bytes per element)) and the pixel height, with M forced to at least 1. Rows per chunk is the largest power of two not above M. Each sub-window descriptor (kind code 1) carries the chunk's first block row in `descRow` and its row count in `descRows`. The last chunk of a slice carries only the rows that remain.
- R6: With `toImage` low, each chunk emits, in this order: a sub-window descriptor (source 0, destination = staging base), a fence (kind code 3), the row descriptors (source = staging, destination = buffer), and a fence.
- R7: With `toImage` high, each chunk emits, in this order: the row descriptors (source = buffer, destination = staging), a fence, a sub-window descriptor (source = staging base, destination 0), and a fence.
- R8: Slices form the outer loop and chunks the inner loop, and `descSlice` gives the slice. The buffer address of a row is buffer base + slice × slice pitch × bytes per element + block row × row pitch × bytes per element, with both pitches given in blocks.
- R9: While `descValid` is high and `descReady` is low, the descriptor and `descValid` stay unchanged.
- R10: `done` goes high for exactly one cycle. It does so in the cycle after the last descriptor of the last slice is accepted, and `descValid` is low in that cycle.
- R11: A start request is ignored while a job is in progress, and it is not queued. Changes on the parameter inputs after a start has been accepted do not affect the running job.
- R12: The descriptor kind codes are 1 for sub-window, 2 for row and 3 for fence. A valid descriptor never carries code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Start request; only accepted when idle |
| toImage | input | 1 | 1 = buffer-to-image, 0 = image-to-buffer |
| widthPx | input | DIM_W | Copy width in pixels |
| heightPx | input | DIM_W | Copy height in pixels |
| depth | input | DIM_W | Number of slices (at least 1) |
| blkW | input | BLK_W | Format block width in pixels (at least 1) |
| blkH | input | BLK_W | Format block height in pixels (at least 1) |
| bpe | input | BPE_W | Bytes per format block |
| bufBase | input | ADDR_W | Buffer base address |
| bufPitchBlk | input | DIM_W | Buffer row pitch in blocks |
| bufSlicePitchBlk | input | SP_W | Buffer slice pitch in blocks |
| stageBase | input | ADDR_W | Staging area base address |
| descValid | output | 1 | Descriptor valid |
| descReady | input | 1 | Downstream accepts the descriptor |
| descKind | output | 2 | 1 sub-window, 2 row, 3 fence |
| descSlice | output | DIM_W | Slice index |
| descRow | output | DIM_W | Block row (chunk start for a sub-window) |
| descRows | output | DIM_W | Block rows covered |
| descSrc | output | ADDR_W | Source address |
| descDst | output | ADDR_W | Destination address |
| descBytes | output | DIM_W+BPE_W | Row byte count (0 for other kinds) |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle: the handshake hold rule, the single-cycle done pulse and the quiet output that goes with it, the legal kind codes, the fence that must follow every accepted sub-window, and the non-zero row and chunk sizes. The exact arithmetic can only be shown by the directed scenarios, which compare each descriptor against a model. That covers block rounding, staging pitch padding, the power-of-two chunk height, remainder chunks, buffer and staging addresses, and the complete per-direction ordering across slices. The same is true of the discard of a start request that arrives mid-job and the capture of the parameters at start.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_WINDOW = 2'd1,
    KIND_ROW    = 2'd2,
    KIND_FENCE  = 2'd3
  } descKind_e;

  typedef struct packed {
    logic capture;
    logic calcDims;
    logic calcChunk;
    logic nextRow;
    logic nextChunk;
  } stepCtl_t;
endpackage

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int DIM_W       = 14,
  parameter int BLK_W       = 4,
  parameter int BPE_W       = 5,
  parameter int ADDR_W      = 32,
  parameter int SP_W        = 28,
  parameter int STAGE_BYTES = 4096
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stepCtl_t               ctl,
  input  descKind_e              kind,
  input  logic                   toImage,
  input  logic [DIM_W-1:0]       widthPx,
  input  logic [DIM_W-1:0]       heightPx,
  input  logic [DIM_W-1:0]       depth,
  input  logic [BLK_W-1:0]       blkW,
  input  logic [BLK_W-1:0]       blkH,
  input  logic [BPE_W-1:0]       bpe,
  input  logic [ADDR_W-1:0]      bufBase,
  input  logic [DIM_W-1:0]       bufPitchBlk,
  input  logic [SP_W-1:0]        bufSlicePitchBlk,
  input  logic [ADDR_W-1:0]      stageBase,
  output logic                   dirToImage,
  output logic                   lastRow,
  output logic                   lastChunk,
  output logic                   lastSlice,
  output logic [DIM_W-1:0]       descSlice,
  output logic [DIM_W-1:0]       descRow,
  output logic [DIM_W-1:0]       descRows,
  output logic [ADDR_W-1:0]      descSrc,
  output logic [ADDR_W-1:0]      descDst,
  output logic [DIM_W+BPE_W-1:0] descBytes
);
  localparam int ROWB_W = DIM_W + BPE_W;
  localparam int SB_W   = DIM_W + 1 + BPE_W;

  // captured job parameters
  logic              toImageQ;
  logic [DIM_W-1:0]  widthQ, heightQ, depthQ, pitchQ;
  logic [BLK_W-1:0]  blkWQ, blkHQ;
  logic [BPE_W-1:0]  bpeQ;
  logic [ADDR_W-1:0] bufBaseQ, stageBaseQ;
  logic [SP_W-1:0]   slicePitchQ;

  // derived geometry and walk position
  logic [DIM_W-1:0]  hBlk, vBlk, rowsPerChunk, rowBase, sliceIdx, rIdx;

  function automatic logic [31:0] floorPow2(input logic [31:0] v);
    logic [31:0] r;
    r = 32'd1;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = 32'd1 << i;
    end
    return r;
  endfunction

  logic [BLK_W-1:0]  wDiv, hDiv;
  logic [DIM_W:0]    stagePitch;
  logic [SB_W-1:0]   stageRowBytes;
  logic [31:0]       fitRows, maxRows;
  logic [DIM_W-1:0]  remaining, chunkRows, curRow;

  assign wDiv = (blkWQ == '0) ? BLK_W'(1) : blkWQ;
  assign hDiv = (blkHQ == '0) ? BLK_W'(1) : blkHQ;
  assign stagePitch    = ({1'b0, hBlk} + (DIM_W+1)'(3)) & {{(DIM_W-1){1'b1}}, 2'b00};
  assign stageRowBytes = SB_W'(stagePitch) * SB_W'(bpeQ);

  always_comb begin
    if (stageRowBytes == '0) fitRows = 32'(STAGE_BYTES);
    else                     fitRows = 32'(STAGE_BYTES) / 32'(stageRowBytes);
    maxRows = (fitRows < 32'(heightQ)) ? fitRows : 32'(heightQ);
    if (maxRows == 32'd0) maxRows = 32'd1;
  end

  assign remaining = vBlk - rowBase;
  assign chunkRows = (remaining < rowsPerChunk) ? remaining : rowsPerChunk;
  assign curRow    = rowBase + rIdx;

  assign dirToImage = toImageQ;
  assign lastRow    = (rIdx + DIM_W'(1)) == chunkRows;
  assign lastChunk  = (32'(rowBase) + 32'(rowsPerChunk)) >= 32'(vBlk);
  assign lastSlice  = (sliceIdx + DIM_W'(1)) == depthQ;

  logic [ADDR_W-1:0] bufAddr, stageAddr;
  assign bufAddr = bufBaseQ
                 + ADDR_W'(sliceIdx) * ADDR_W'(slicePitchQ) * ADDR_W'(bpeQ)
                 + ADDR_W'(curRow) * ADDR_W'(pitchQ) * ADDR_W'(bpeQ);
  assign stageAddr = stageBaseQ + ADDR_W'(rIdx) * ADDR_W'(stagePitch) * ADDR_W'(bpeQ);

  always_comb begin
    descSlice = '0;
    descRow   = '0;
    descRows  = '0;
    descSrc   = '0;
    descDst   = '0;
    descBytes = '0;
    case (kind)
      KIND_WINDOW: begin
        descSlice = sliceIdx;
        descRow   = rowBase;
        descRows  = chunkRows;
        if (toImageQ) descSrc = stageBaseQ;
        else          descDst = stageBaseQ;
      end
      KIND_ROW: begin
        descSlice = sliceIdx;
        descRow   = curRow;
        descRows  = DIM_W'(1);
        descBytes = ROWB_W'(hBlk) * ROWB_W'(bpeQ);
        descSrc   = toImageQ ? bufAddr : stageAddr;
        descDst   = toImageQ ? stageAddr : bufAddr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toImageQ     <= 1'b0;
      widthQ       <= '0;
      heightQ      <= '0;
      depthQ       <= '0;
      pitchQ       <= '0;
      blkWQ        <= '0;
      blkHQ        <= '0;
      bpeQ         <= '0;
      bufBaseQ     <= '0;
      stageBaseQ   <= '0;
      slicePitchQ  <= '0;
      hBlk         <= '0;
      vBlk         <= '0;
      rowsPerChunk <= '0;
      rowBase      <= '0;
      sliceIdx     <= '0;
      rIdx         <= '0;
    end else begin
      if (ctl.capture) begin
        toImageQ    <= toImage;
        widthQ      <= widthPx;
        heightQ     <= heightPx;
        depthQ      <= depth;
        pitchQ      <= bufPitchBlk;
        blkWQ       <= blkW;
        blkHQ       <= blkH;
        bpeQ        <= bpe;
        bufBaseQ    <= bufBase;
        stageBaseQ  <= stageBase;
        slicePitchQ <= bufSlicePitchBlk;
      end
      if (ctl.calcDims) begin
        hBlk <= DIM_W'((32'(widthQ) + 32'(wDiv) - 32'd1) / 32'(wDiv));
        vBlk <= DIM_W'((32'(heightQ) + 32'(hDiv) - 32'd1) / 32'(hDiv));
      end
      if (ctl.calcChunk) begin
        rowsPerChunk <= DIM_W'(floorPow2(maxRows));
        rowBase      <= '0;
        sliceIdx     <= '0;
        rIdx         <= '0;
      end
      if (ctl.nextRow) rIdx <= rIdx + DIM_W'(1);
      if (ctl.nextChunk) begin
        rIdx <= '0;
        if (lastChunk) begin
          rowBase  <= '0;
          sliceIdx <= sliceIdx + DIM_W'(1);
        end else begin
          rowBase <= rowBase + rowsPerChunk;
        end
      end
    end
  end
endmodule

// File: rtl/rcs_control.sv
module rcs_control
  import rcs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      descReady,
  input  logic      dirToImage,
  input  logic      lastRow,
  input  logic      lastChunk,
  input  logic      lastSlice,
  output stepCtl_t  ctl,
  output descKind_e kind,
  output logic      descValid,
  output logic      done
);
  typedef enum logic [1:0] {ST_IDLE, ST_DIMS, ST_CHUNK, ST_EMIT} state_e;

  state_e     state;
  logic [1:0] phase;
  logic       fire;
  logic       finalFire;

  // phase 0..3 per chunk; direction picks which half carries the rows
  always_comb begin
    kind = KIND_NONE;
    if (state == ST_EMIT) begin
      case (phase)
        2'd0:    kind = dirToImage ? KIND_ROW : KIND_WINDOW;
        2'd2:    kind = dirToImage ? KIND_WINDOW : KIND_ROW;
        default: kind = KIND_FENCE;
      endcase
    end
  end

  assign descValid = (state == ST_EMIT);
  assign fire      = descValid && descReady;
  assign finalFire = fire && (phase == 2'd3) && lastChunk && lastSlice;

  always_comb begin
    ctl           = '0;
    ctl.capture   = (state == ST_IDLE) && start;
    ctl.calcDims  = (state == ST_DIMS);
    ctl.calcChunk = (state == ST_CHUNK);
    ctl.nextRow   = fire && (kind == KIND_ROW) && !lastRow;
    ctl.nextChunk = fire && (phase == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= 2'd0;
      done  <= 1'b0;
    end else begin
      done <= finalFire;
      case (state)
        ST_IDLE:  if (start) state <= ST_DIMS;
        ST_DIMS:  state <= ST_CHUNK;
        ST_CHUNK: begin
          state <= ST_EMIT;
          phase <= 2'd0;
        end
        ST_EMIT: begin
          if (fire && !(kind == KIND_ROW && !lastRow)) begin
            if (phase == 2'd3) begin
              phase <= 2'd0;
              if (lastChunk && lastSlice) state <= ST_IDLE;
            end else begin
              phase <= phase + 2'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/row_chunk_seq.sv
module row_chunk_seq
  import rcs_pkg::*;
#(
  parameter int DIM_W       = 14,
  parameter int BLK_W       = 4,
  parameter int BPE_W       = 5,
  parameter int ADDR_W      = 32,
  parameter int SP_W        = 28,
  parameter int STAGE_BYTES = 4096
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   toImage,
  input  logic [DIM_W-1:0]       widthPx,
  input  logic [DIM_W-1:0]       heightPx,
  input  logic [DIM_W-1:0]       depth,
  input  logic [BLK_W-1:0]       blkW,
  input  logic [BLK_W-1:0]       blkH,
  input  logic [BPE_W-1:0]       bpe,
  input  logic [ADDR_W-1:0]      bufBase,
  input  logic [DIM_W-1:0]       bufPitchBlk,
  input  logic [SP_W-1:0]        bufSlicePitchBlk,
  input  logic [ADDR_W-1:0]      stageBase,
  output logic                   descValid,
  input  logic                   descReady,
  output logic [1:0]             descKind,
  output logic [DIM_W-1:0]       descSlice,
  output logic [DIM_W-1:0]       descRow,
  output logic [DIM_W-1:0]       descRows,
  output logic [ADDR_W-1:0]      descSrc,
  output logic [ADDR_W-1:0]      descDst,
  output logic [DIM_W+BPE_W-1:0] descBytes,
  output logic                   done
);
  stepCtl_t  ctl;
  descKind_e kind;
  logic      dirToImage, lastRow, lastChunk, lastSlice;

  rcs_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .descReady(descReady),
    .dirToImage(dirToImage), .lastRow(lastRow), .lastChunk(lastChunk),
    .lastSlice(lastSlice), .ctl(ctl), .kind(kind),
    .descValid(descValid), .done(done)
  );

  rcs_datapath #(
    .DIM_W(DIM_W), .BLK_W(BLK_W), .BPE_W(BPE_W),
    .ADDR_W(ADDR_W), .SP_W(SP_W), .STAGE_BYTES(STAGE_BYTES)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .kind(kind), .toImage(toImage),
    .widthPx(widthPx), .heightPx(heightPx), .depth(depth),
    .blkW(blkW), .blkH(blkH), .bpe(bpe), .bufBase(bufBase),
    .bufPitchBlk(bufPitchBlk), .bufSlicePitchBlk(bufSlicePitchBlk),
    .stageBase(stageBase), .dirToImage(dirToImage), .lastRow(lastRow),
    .lastChunk(lastChunk), .lastSlice(lastSlice), .descSlice(descSlice),
    .descRow(descRow), .descRows(descRows), .descSrc(descSrc),
    .descDst(descDst), .descBytes(descBytes)
  );

  assign descKind = kind;
endmodule

// File: rtl/row_chunk_seq_checker.sv
module row_chunk_seq_checker #(
  parameter int DIM_W  = 14,
  parameter int BPE_W  = 5,
  parameter int ADDR_W = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   descValid,
  input logic                   descReady,
  input logic [1:0]             descKind,
  input logic [DIM_W-1:0]       descSlice,
  input logic [DIM_W-1:0]       descRow,
  input logic [DIM_W-1:0]       descRows,
  input logic [ADDR_W-1:0]      descSrc,
  input logic [ADDR_W-1:0]      descDst,
  input logic [DIM_W+BPE_W-1:0] descBytes,
  input logic                   done
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady |=> descValid && $stable(descKind) && $stable(descSlice)
      && $stable(descRow) && $stable(descRows) && $stable(descSrc)
      && $stable(descDst) && $stable(descBytes)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(descValid && descReady) && !descValid); // R10

  AST_WINDOW_THEN_FENCE: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descReady && descKind == 2'd1 |=> descValid && descKind == 2'd3); // R6

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> descKind != 2'd0); // R12

  AST_ROW_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descKind == 2'd2 |-> descBytes != '0 && descRows == DIM_W'(1)); // R2

  AST_CHUNK_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    descValid && descKind == 2'd1 |-> descRows != '0); // R5
endmodule

bind row_chunk_seq row_chunk_seq_checker #(
  .DIM_W(DIM_W), .BPE_W(BPE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .descValid(descValid), .descReady(descReady),
  .descKind(descKind), .descSlice(descSlice), .descRow(descRow),
  .descRows(descRows), .descSrc(descSrc), .descDst(descDst),
  .descBytes(descBytes), .done(done)
);

// File: tb/row_chunk_seq_test.sv
module row_chunk_seq_test;
  localparam int CLK_PERIOD  = 10;
  localparam int STAGE_BYTES = 4096;
  localparam int DIM_W = 14;
  localparam int BLK_W = 4;
  localparam int BPE_W = 5;
  localparam int ADDR_W = 32;
  localparam int SP_W = 28;
  localparam int K_WIN = 1, K_ROW = 2, K_FENCE = 3;
  localparam longint BUF_BASE   = 64'h1000_0000;
  localparam longint STAGE_BASE = 64'h0008_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic toImage = 1'b0;
  logic [DIM_W-1:0] widthPx = '0, heightPx = '0, depth = '0, bufPitchBlk = '0;
  logic [BLK_W-1:0] blkW = '0, blkH = '0;
  logic [BPE_W-1:0] bpe = '0;
  logic [ADDR_W-1:0] bufBase = '0, stageBase = '0;
  logic [SP_W-1:0] bufSlicePitchBlk = '0;
  logic descReady = 1'b0;
  logic descValid, done;
  logic [1:0] descKind;
  logic [DIM_W-1:0] descSlice, descRow, descRows;
  logic [ADDR_W-1:0] descSrc, descDst;
  logic [DIM_W+BPE_W-1:0] descBytes;

  int checks = 0;
  int errors = 0;
  int descIdx = 0;
  int injectAt = -1;
  bit stallMode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  row_chunk_seq #(.STAGE_BYTES(STAGE_BYTES)) uut (
    .clk(clk), .rstN(rstN), .start(start), .toImage(toImage),
    .widthPx(widthPx), .heightPx(heightPx), .depth(depth), .blkW(blkW),
    .blkH(blkH), .bpe(bpe), .bufBase(bufBase), .bufPitchBlk(bufPitchBlk),
    .bufSlicePitchBlk(bufSlicePitchBlk), .stageBase(stageBase),
    .descValid(descValid), .descReady(descReady), .descKind(descKind),
    .descSlice(descSlice), .descRow(descRow), .descRows(descRows),
    .descSrc(descSrc), .descDst(descDst), .descBytes(descBytes), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareDesc(input string ordTag, input int kind, input int slc, input int row,
                             input int rows, input longint src, input longint dst, input int bytes);
    chk(ordTag, "kind", descKind, kind);
    if (kind == K_WIN) begin
      chk("R8", "window slice", descSlice, slc);
      chk("R5", "window first row", descRow, row);
      chk("R5", "window rows", descRows, rows);
      chk("R12", "window src", descSrc, src);
      chk("R12", "window dst", descDst, dst);
    end else if (kind == K_ROW) begin
      chk("R8", "row slice", descSlice, slc);
      chk("R3", "row index", descRow, row);
      chk("R3", "row count", descRows, 1);
      chk("R4", "row src", descSrc, src);
      chk("R8", "row dst", descDst, dst);
      chk("R2", "row bytes", descBytes, bytes);
    end
  endtask

  // waits for a descriptor, checks it, then lets it be accepted
  task automatic nextDesc(input string ordTag, input int kind, input int slc, input int row,
                          input int rows, input longint src, input longint dst, input int bytes);
    int t = 0;
    while (!descValid && t < 1000) begin
      @(negedge clk);
      t++;
    end
    chk(ordTag, "descValid present", descValid, 1);
    compareDesc(ordTag, kind, slc, row, rows, src, dst, bytes);
    if (descIdx == injectAt) begin
      start = 1'b1;
      toImage = ~toImage;
      widthPx = 14'd3;
      heightPx = 14'd1;
      depth = 14'd1;
    end
    if (stallMode) begin
      @(negedge clk);
      chk("R9", "valid held while stalled", descValid, 1);
      compareDesc("R9", kind, slc, row, rows, src, dst, bytes);
      descReady = 1'b1;
      @(negedge clk);
      descReady = 1'b0;
    end else begin
      @(negedge clk);
    end
    start = 1'b0;
    descIdx++;
  endtask

  task automatic runCopy(input bit dirIn, input int w, input int h, input int d,
                         input int bw, input int bh, input int bp,
                         input int pitchB, input int sliceB, input bit stall, input int inj);
    int hb, vb, sp, rb, fit, mx, rpc;
    string ordTag;
    ordTag = dirIn ? "R7" : "R6";
    hb = (w + bw - 1) / bw;
    vb = (h + bh - 1) / bh;
    sp = ((hb + 3) / 4) * 4;
    rb = sp * bp;
    fit = STAGE_BYTES / rb;
    mx = (fit < h) ? fit : h;
    if (mx < 1) mx = 1;
    rpc = 1;
    while (rpc * 2 <= mx) rpc = rpc * 2;
    stallMode = stall;
    injectAt = inj;
    descIdx = 0;
    descReady = !stall;
    @(negedge clk);
    toImage = dirIn;
    widthPx = DIM_W'(w);
    heightPx = DIM_W'(h);
    depth = DIM_W'(d);
    blkW = BLK_W'(bw);
    blkH = BLK_W'(bh);
    bpe = BPE_W'(bp);
    bufPitchBlk = DIM_W'(pitchB);
    bufSlicePitchBlk = SP_W'(sliceB);
    bufBase = ADDR_W'(BUF_BASE);
    stageBase = ADDR_W'(STAGE_BASE);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble inputs after capture
    widthPx = 14'd777;
    bpe = 5'd1;
    bufPitchBlk = 14'd5;
    bufBase = 32'hDEAD_0000;
    for (int s = 0; s < d; s++) begin
      for (int r0 = 0; r0 < vb; r0 += rpc) begin
        int n;
        n = (vb - r0 < rpc) ? (vb - r0) : rpc;
        if (!dirIn) begin
          nextDesc(ordTag, K_WIN, s, r0, n, 0, STAGE_BASE, 0);
          nextDesc(ordTag, K_FENCE, 0, 0, 0, 0, 0, 0);
        end
        for (int k = 0; k < n; k++) begin
          longint bA, sA;
          bA = BUF_BASE + longint'(s) * sliceB * bp + longint'(r0 + k) * pitchB * bp;
          sA = STAGE_BASE + longint'(k) * sp * bp;
          if (dirIn) nextDesc(ordTag, K_ROW, s, r0 + k, 1, bA, sA, hb * bp);
          else       nextDesc(ordTag, K_ROW, s, r0 + k, 1, sA, bA, hb * bp);
        end
        nextDesc(ordTag, K_FENCE, 0, 0, 0, 0, 0, 0);
        if (dirIn) begin
          nextDesc(ordTag, K_WIN, s, r0, n, STAGE_BASE, 0, 0);
          nextDesc(ordTag, K_FENCE, 0, 0, 0, 0, 0, 0);
        end
      end
    end
    chk("R10", "done after last accept", done, 1);
    chk("R10", "valid low with done", descValid, 0);
    @(negedge clk);
    chk("R10", "done one cycle", done, 0);
    descReady = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk("R11", "no queued job after end", descValid, 0);
    descReady = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "descValid after reset", descValid, 0);
    chk("R1", "done after reset", done, 0);
    @(negedge clk);
    chk("R1", "descValid idle", descValid, 0);
  endtask

  // image-to-buffer; rows limited by height (5 -> 4 per chunk, remainder 1)
  task automatic testImgToBufHeightBound();
    runCopy(1'b0, 10, 5, 1, 1, 1, 4, 16, 200, 1'b0, -1);
  endtask

  // buffer-to-image, two slices, staging bound (5 -> 4), stalled handshake
  task automatic testBufToImgSlicesStall();
    runCopy(1'b1, 100, 6, 2, 1, 1, 8, 128, 1000, 1'b1, -1);
  endtask

  // 4x4 compressed blocks: 13x10 px -> 4x3 blocks, chunk of 3 rows
  task automatic testBlockFormat();
    runCopy(1'b0, 13, 10, 1, 4, 4, 16, 6, 40, 1'b0, -1);
  endtask

  // wide rows: only one row fits, one-row chunks
  task automatic testOneRowChunks();
    runCopy(1'b1, 1000, 3, 1, 1, 1, 4, 1000, 3000, 1'b0, -1);
  endtask

  // start pulse during a job is discarded
  task automatic testStartWhileBusy();
    runCopy(1'b0, 20, 4, 2, 1, 1, 2, 24, 100, 1'b0, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImgToBufHeightBound();
    testBufToImgSlicesStall();
    testBlockFormat();
    testOneRowChunks();
    testStartWhileBusy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule